// File: doc/BRIEF.md
# Zero-Overhead Static Loop Controller

This controller repeats a loop body whose latency is fixed at `BODY_LEN` cycles for as long as a registered condition remains true. It drives the body with an active strobe and a cycle index. The index steps from 0 up to `BODY_LEN-1` and then returns straight to 0. The loop condition is tested only while the index is 0, and that test sits inside the body's own count. Iterations therefore follow each other with no separate cycle spent on deciding whether to continue.

A parent raises `go_i` and holds it high. While the loop runs, the strobe stays high on every cycle. The controller raises `done_o` in the first index-0 cycle in which `cond_i` is low, and the parent may then drop `go_i`. The condition has to come from a register, so it holds steady through the index-0 cycle in which it is tested. If the condition is already low when `go_i` rises, the loop finishes at once and runs no iterations.

Top module: `static_loop_ctrl`

## Requirements
- R1: While `body_go_o` is high and the index is below `BODY_LEN-1`, `body_idx_o` increases by one at the next clock edge.
- R2: From index `BODY_LEN-1` with `body_go_o` high, the index returns to 0 at the next edge, and `body_go_o` stays high, so iterations have no gap cycle between them.
- R3: From the cycle `go_i` rises until the cycle the loop finishes, `body_go_o` is high on every cycle.
- R4: `done_o` is high in a cycle exactly when `go_i` is high, the loop has not already finished, `body_idx_o` is 0 and `cond_i` is low. The value of `cond_i` at any nonzero index has no effect.
- R5: If `cond_i` is low when `go_i` rises, `done_o` is high in that same cycle, `body_go_o` never rises, and no iteration runs.
- R6: `body_go_o` is low in any cycle in which `done_o` is high.
- R7: `done_o` lasts one cycle. While `go_i` stays high afterwards, `done_o` and `body_go_o` stay low and the index holds at 0. Lowering `go_i` for a cycle and raising it again starts a new run at index 0.
- R8: An active-low `rst_n` returns the index to 0 and clears the finished state. With `go_i` low, `done_o` and `body_go_o` are then low.
- R9: With `BODY_LEN` = 1, the index is always 0, every strobe cycle is one iteration, and the condition is tested on every cycle.
- R10: Take a 3-cycle body that forms value+1 at index 0, writes it back at index 1 and registers (value < 6) as the condition at index 2, with the value starting at 0 and the condition preset true. It runs exactly 6 iterations, raises `done_o` 18 cycles after `go_i` rises, and leaves the value at 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| go_i | input | 1 | Start request from the parent, held high until done |
| cond_i | input | 1 | Registered loop condition, tested at index 0 |
| body_go_o | output | 1 | Body active strobe |
| body_idx_o | output | IDX_W | Current cycle index of the body, 0 to BODY_LEN-1 |
| done_o | output | 1 | One-cycle loop completion |

## Verification
The case that is hardest to reach from the ports is a condition that goes low partway through an iteration and is true again by the time the index wraps to 0. Because the condition is tested only at index 0, this must not end the loop. The stimulus lowers `cond_i` at index 1 and restores it before the wrap. The bench then checks that no done appears and that the strobe continues without a gap. A second case drops reset partway through a run and confirms that the next run starts cleanly from index 0.

// File: rtl/static_loop_pkg.sv
package static_loop_pkg;

  // Index width for a body of len cycles; at least one bit.
  function automatic int idx_width(input int len);
    int w;
    w = 1;
    while ((1 << w) < len) w++;
    return w;
  endfunction

  // Decision taken by the exit logic in a given cycle.
  typedef enum logic [1:0] {
    LOOP_IDLE = 2'd0,
    LOOP_RUN  = 2'd1,
    LOOP_EXIT = 2'd2
  } loop_step_e;

endpackage

// File: rtl/static_loop_idx.sv
module static_loop_idx #(
  parameter  int LEN   = 3,
  localparam int IDX_W = static_loop_pkg::idx_width(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);

  generate
    if (LEN <= 1) begin : g_single
      // A one-cycle body never leaves index 0.
      assign idx_o = '0;
    end else begin : g_count
      localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

      logic [IDX_W-1:0] idx_q;
      logic [IDX_W-1:0] idx_d;
      logic             wrap;

      assign wrap = (idx_q == LAST);

      always_comb begin
        idx_d = idx_q;
        if (adv_i) begin
          if (wrap) idx_d = '0;
          else      idx_d = idx_q + IDX_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx_q <= '0;
        else if (adv_i) idx_q <= idx_d;
      end

      assign idx_o = idx_q;

      assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

      assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && idx_q == LAST) |=> (idx_q == '0));

      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(idx_q));

      assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);
    end
  endgenerate

endmodule

// File: rtl/static_loop_exit.sv
module static_loop_exit
  import static_loop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic cond_i,
  input  logic at_zero_i,
  output logic strobe_o,
  output logic done_o
);

  logic       fin_q;
  logic       fin_d;
  loop_step_e step;

  // Decide what this cycle is: idle, body cycle, or exit.
  always_comb begin
    step = LOOP_IDLE;
    if (go_i && !fin_q) begin
      if (at_zero_i && !cond_i) step = LOOP_EXIT;
      else                      step = LOOP_RUN;
    end
  end

  assign strobe_o = (step == LOOP_RUN);
  assign done_o   = (step == LOOP_EXIT);

  // Finished flag: set on exit, kept while go stays high.
  always_comb begin
    fin_d = fin_q;
    if (!go_i)       fin_d = 1'b0;
    else if (done_o) fin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= fin_d;
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !strobe_o));

  assert_no_strobe_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && strobe_o));

endmodule

// File: rtl/static_loop_ctrl.sv
module static_loop_ctrl #(
  parameter  int BODY_LEN = 3,
  localparam int IDX_W    = static_loop_pkg::idx_width(BODY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             cond_i,
  output logic             body_go_o,
  output logic [IDX_W-1:0] body_idx_o,
  output logic             done_o
);

  logic [IDX_W-1:0] idx;
  logic             strobe;
  logic             done;
  logic             at_zero;

  assign at_zero = (idx == '0);

  static_loop_idx #(.LEN(BODY_LEN)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (strobe),
    .idx_o (idx)
  );

  static_loop_exit u_exit (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .cond_i    (cond_i),
    .at_zero_i (at_zero),
    .strobe_o  (strobe),
    .done_o    (done)
  );

  assign body_go_o  = strobe;
  assign body_idx_o = idx;
  assign done_o     = done;

  assert_done_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (body_idx_o == '0 && !cond_i));

  assert_cond_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (body_idx_o != '0) |-> !done_o);

  assert_exit_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (body_idx_o == '0));

endmodule

// File: tb/tb_static_loop_ctrl.sv
module tb_static_loop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;

  logic       clk;
  logic       rst_n;
  logic       go;
  logic       cond;
  logic       strobe;
  logic [1:0] idx;
  logic       done;

  logic       go1;
  logic       cond1;
  logic       strobe1;
  logic [0:0] idx1;
  logic       done1;

  int n_chk;
  int n_bad;
  int cyc;

  static_loop_ctrl #(.BODY_LEN(3)) dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .cond_i(cond),
    .body_go_o(strobe), .body_idx_o(idx), .done_o(done)
  );

  static_loop_ctrl #(.BODY_LEN(1)) dut_n1 (
    .clk(clk), .rst_n(rst_n), .go_i(go1), .cond_i(cond1),
    .body_go_o(strobe1), .body_idx_o(idx1), .done_o(done1)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cyc, WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; go = 0; cond = 0; go1 = 0; cond1 = 0;
    repeat (2) tick();
    @(negedge clk);
    chk("R8 reset idx", int'(idx), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset strobe", int'(strobe), 0);
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_zero_iter();
    cond = 0; go = 1;
    @(negedge clk);
    chk("R5 done at once", int'(done), 1);
    chk("R6 strobe low on exit", int'(strobe), 0);
    chk("R5 idx", int'(idx), 0);
    tick();
    @(negedge clk);
    chk("R7 done drops", int'(done), 0);
    chk("R5 no iteration", int'(strobe), 0);
    tick();
    go = 0;
    tick();
  endtask

  task automatic t_scenario();
    int v, tmp, iters, done_at;
    logic nxt;
    v = 0; tmp = 0; iters = 0; done_at = -1; nxt = 1'b1;
    cond = 1; go = 1;
    for (int k = 0; k < 40; k++) begin
      int cur;
      @(negedge clk);
      if (done) begin
        done_at = k;
        chk("R6 strobe low on exit", int'(strobe), 0);
        chk("R4 exit at idx 0", int'(idx), 0);
        break;
      end
      chk("R3 strobe held", int'(strobe), 1);
      chk("R1 R2 idx sequence", int'(idx), k % 3);
      cur = int'(idx);
      case (cur)
        0: tmp = v + 1;
        1: v = tmp;
        default: begin nxt = (v < 6); iters++; end
      endcase
      tick();
      if (cur == 2) cond = nxt;
    end
    chk("R10 done cycle", done_at, 18);
    chk("R10 iterations", iters, 6);
    chk("R10 final value", v, 6);
    tick();
    go = 0;
    tick();
  endtask

  task automatic t_cond_ignored();
    cond = 1; go = 1;
    @(negedge clk);
    chk("R3 start strobe", int'(strobe), 1);
    tick();
    cond = 0;
    @(negedge clk);
    chk("R4 idx 1", int'(idx), 1);
    chk("R4 cond ignored idx1", int'(done), 0);
    chk("R4 strobe idx1", int'(strobe), 1);
    tick();
    cond = 1;
    @(negedge clk);
    chk("R4 cond ignored idx2", int'(done), 0);
    tick();
    cond = 0;
    @(negedge clk);
    chk("R2 wrapped", int'(idx), 0);
    chk("R4 exit on low cond", int'(done), 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      @(negedge clk);
      chk("R7 quiet done", int'(done), 0);
      chk("R7 quiet strobe", int'(strobe), 0);
      chk("R7 idx parked", int'(idx), 0);
    end
    tick();
    go = 0;
    tick();
    cond = 1; go = 1;
    @(negedge clk);
    chk("R7 restart strobe", int'(strobe), 1);
    chk("R7 restart idx", int'(idx), 0);
    tick();
    @(negedge clk);
    chk("R7 restart advances", int'(idx), 1);
    tick();
  endtask

  task automatic t_reset_midrun();
    @(negedge clk);
    chk("R1 mid-run idx", int'(idx), 2);
    tick();
    rst_n = 1'b0; go = 0; cond = 0;
    @(negedge clk);
    chk("R8 mid-run idx", int'(idx), 0);
    chk("R8 mid-run done", int'(done), 0);
    chk("R8 mid-run strobe", int'(strobe), 0);
    tick();
    rst_n = 1'b1;
    tick();
    cond = 1; go = 1;
    @(negedge clk);
    chk("R8 clean start idx", int'(idx), 0);
    chk("R8 clean start strobe", int'(strobe), 1);
    tick();
    cond = 0;
    tick();
    tick();
    @(negedge clk);
    chk("R8 clean exit", int'(done), 1);
    tick();
    go = 0;
    tick();
  endtask

  task automatic t_len_one();
    cond1 = 1; go1 = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 idx zero", int'(idx1), 0);
      chk("R9 strobe", int'(strobe1), 1);
      chk("R9 no done", int'(done1), 0);
      tick();
    end
    cond1 = 0;
    @(negedge clk);
    chk("R9 exit next test", int'(done1), 1);
    chk("R9 strobe on exit", int'(strobe1), 0);
    tick();
    go1 = 0;
    tick();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0;
    t_reset();
    t_zero_iter();
    t_scenario();
    t_cond_ignored();
    t_reset_midrun();
    t_len_one();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule